// File: doc/BRIEF.md
# Burst Command Decoder and Sequencer

This block sits behind the control pins of a synchronous burst memory. On every rising clock edge it samples three burst-control inputs, an order-select input and an address. From them it works out whether the cycle starts a new burst (a read or a write, at single or double data rate), continues the running burst, or is idle. It keeps the upper address bits fixed for the whole burst and steps the two low bits through a four-beat sequence, in interleaved or linear order.

Two beat addresses are presented each cycle. One is for the rising-edge transfer. The other is the following beat, for the falling-edge transfer in double-data-rate mode. The block also reports the operation type and the data-rate mode, plus a read output-enable flag that trails the active read burst by one clock. The memory array and the pad drivers are built elsewhere and consume these outputs.

Top module: `burst_seq`

## Requirements
- R1: During and right after a synchronous active-low reset, the block is idle. `burst_active`, `out_en`, `op_write`, `op_ddr` are 0, and `beat_addr` is 0.
- R2: A clock edge with `ld_n`=0 loads `addr_in` and starts a burst. `beat_addr` equals `addr_in` after that edge. `op_write` is 1 when `ctl_rw` was 0 (a write) and 0 when it was 1 (a read). `op_ddr` is 1 when `ctl_sdr` was 0 and 0 when it was 1.
- R3: With `order_ilv`=1 at load, the low two bits of beat n are the start bits XOR n.
- R4: With `order_ilv`=0 at load, the low two bits of beat n are the start bits plus n, modulo 4.
- R5: A continue (`ld_n`=1, `ctl_rw`=1, burst active) advances the beat index by 1 in single-rate mode and by 2 in double-rate mode. `beat_addr_pair` always shows beat index + 1.
- R6: Continues beyond the fourth beat wrap within the same four-beat group. The beat index counts modulo 4.
- R7: The upper address bits (all above bit 1) of both beat outputs stay at the loaded value during continues, even when `addr_in` changes.
- R8: An edge with `ld_n`=1 and `ctl_rw`=0 ends the burst, so `burst_active` is 0 after it. `out_en` falls one clock later.
- R9: A continue that arrives while no burst is active behaves as a no-operation. `burst_active` stays 0 and `beat_addr` holds its value.
- R10: `out_en` is 1 exactly one clock after a cycle in which a read burst was active. It stays 0 for write bursts.
- R11: The order mode, operation and data rate are latched at load. Changing `order_ilv`, `ctl_sdr` or `ctl_rw` during continues has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Load-new-address control, active low |
| ctl_rw | input | 1 | At load: 1 read, 0 write. Otherwise: 1 continue, 0 stop |
| ctl_sdr | input | 1 | At load: 1 single data rate, 0 double |
| order_ilv | input | 1 | At load: 1 interleaved order, 0 linear |
| addr_in | input | ADDR_W | Burst start address |
| beat_addr | output | ADDR_W | Address of the current (rising-edge) beat |
| beat_addr_pair | output | ADDR_W | Address of the following (falling-edge) beat |
| burst_active | output | 1 | A burst is in progress |
| op_write | output | 1 | Current burst is a write |
| op_ddr | output | 1 | Current burst is double data rate |
| out_en | output | 1 | Read data drive enable, one clock behind the read burst |

## Verification
The patterns are a single-rate burst from each start offset in both orders, extended past four beats, which separates XOR from add ordering and exposes the wrap. Double-rate bursts with odd starts show whether a continue steps by two and whether the paired beat is index + 1. Write bursts, stop cycles and continues while idle tell the read-enable pipeline apart from the active flag. Changing the address and mode inputs mid-burst shows that only the load cycle samples them.

// File: rtl/burst_seq_pkg.sv
// Package: shared helpers for the burst sequencer.
// Assumes a four-beat burst group, so the beat index is two bits wide.
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // Low address bits for beat n from start s in the selected order.
    function automatic beat_t beat_order(input beat_t s, input beat_t n, input logic ilv);
        return ilv ? (s ^ n) : beat_t'(s + n);
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
// Module: burst_cmd_decode
// Turns the sampled control pins into one of load, step or stop.
// Assumes the caller provides the current burst-active state. A step
// request with no active burst is folded into stop.
module burst_cmd_decode (
    input  logic ld_n,
    input  logic ctl_rw,
    input  logic active,
    output logic is_load,
    output logic is_step,
    output logic is_stop
);

    // Purpose: classify the current cycle.
    always_comb begin
        is_load = !ld_n;
        is_step = ld_n && ctl_rw && active;
        is_stop = ld_n && !(ctl_rw && active);
    end

endmodule

// File: rtl/burst_lane_order.sv
// Module: burst_lane_order
// Computes one beat address lane: upper bits pass through, and the low
// bits follow the burst order for (index + OFFS).
// Assumes a two-bit beat index that wraps modulo 4.
module burst_lane_order #(
    parameter int ADDR_W = 18,
    parameter int OFFS   = 0
) (
    input  logic [ADDR_W-3:0] upper,
    input  logic [1:0]        start,
    input  logic [1:0]        idx,
    input  logic              ilv,
    output logic [ADDR_W-1:0] addr
);
    import burst_seq_pkg::*;

    localparam beat_t LANE_OFFS = beat_t'(OFFS);

    // Purpose: join fixed upper bits with ordered low bits.
    always_comb begin
        addr = {upper, beat_order(start, beat_t'(idx + LANE_OFFS), ilv)};
    end

endmodule

// File: rtl/burst_state.sv
// Module: burst_state
// Holds the burst context: upper address, start bits, beat index, latched
// modes and the one-clock-delayed read output enable.
// Assumes exactly one of load/step/stop is high in each cycle.
module burst_state #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_load,
    input  logic              is_step,
    input  logic              is_stop,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctl_rw,
    input  logic              ctl_sdr,
    input  logic              order_ilv,
    output logic              active,
    output logic              wr,
    output logic              ddr,
    output logic              ilv,
    output logic [ADDR_W-3:0] upper,
    output logic [1:0]        start,
    output logic [1:0]        idx,
    output logic              oe
);

    // Purpose: read enable trails the active read burst by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) oe <= 1'b0;
        else        oe <= active && !wr;
    end

    // Purpose: update the burst context from the decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            wr     <= 1'b0;
            ddr    <= 1'b0;
            ilv    <= 1'b0;
            upper  <= '0;
            start  <= '0;
            idx    <= '0;
        end else if (is_load) begin
            active <= 1'b1;
            wr     <= !ctl_rw;
            ddr    <= !ctl_sdr;
            ilv    <= order_ilv;
            upper  <= addr_in[ADDR_W-1:2];
            start  <= addr_in[1:0];
            idx    <= '0;
        end else if (is_step) begin
            idx    <= idx + (ddr ? 2'd2 : 2'd1);
        end else if (is_stop) begin
            active <= 1'b0;
        end
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (active && start == $past(addr_in[1:0]) && upper == $past(addr_in[ADDR_W-1:2])
                     && idx == 2'd0 && wr == !$past(ctl_rw) && ddr == !$past(ctl_sdr)));

    assert_modes_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_step |=> ($stable(wr) && $stable(ddr) && $stable(ilv) && $stable(start)));

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |=> !active);

    assert_oe_trails_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !oe);

endmodule

// File: rtl/burst_seq.sv
// Module: burst_seq (top)
// Burst command decoder and four-beat address sequencer. Samples the
// control pins on each rising edge and drives the current and paired beat
// addresses, the latched operation and rate, and a read output enable.
// Assumes ADDR_W >= 3 so that at least one upper address bit exists.
module burst_seq #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ctl_rw,
    input  logic              ctl_sdr,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [ADDR_W-1:0] beat_addr_pair,
    output logic              burst_active,
    output logic              op_write,
    output logic              op_ddr,
    output logic              out_en
);

    localparam int LANES = 2;

    logic              is_load, is_step, is_stop;
    logic              ilv_q;
    logic [ADDR_W-3:0] upper_q;
    logic [1:0]        start_q, idx_q;
    logic [ADDR_W-1:0] lane_addr [LANES];

    burst_cmd_decode u_dec (
        .ld_n    (ld_n),
        .ctl_rw  (ctl_rw),
        .active  (burst_active),
        .is_load (is_load),
        .is_step (is_step),
        .is_stop (is_stop)
    );

    burst_state #(.ADDR_W(ADDR_W)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_load   (is_load),
        .is_step   (is_step),
        .is_stop   (is_stop),
        .addr_in   (addr_in),
        .ctl_rw    (ctl_rw),
        .ctl_sdr   (ctl_sdr),
        .order_ilv (order_ilv),
        .active    (burst_active),
        .wr        (op_write),
        .ddr       (op_ddr),
        .ilv       (ilv_q),
        .upper     (upper_q),
        .start     (start_q),
        .idx       (idx_q),
        .oe        (out_en)
    );

    // One order lane per beat transferred in a cycle (rising, falling).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        burst_lane_order #(.ADDR_W(ADDR_W), .OFFS(g)) u_lane (
            .upper (upper_q),
            .start (start_q),
            .idx   (idx_q),
            .ilv   (ilv_q),
            .addr  (lane_addr[g])
        );
    end

    // Purpose: route lanes to the output ports.
    always_comb begin
        beat_addr      = lane_addr[0];
        beat_addr_pair = lane_addr[1];
    end

    assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({is_load, is_step, is_stop}));

    assert_idle_cont_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && ld_n) |=> (!burst_active && $stable(beat_addr)));

    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_step |=> ($stable(beat_addr[ADDR_W-1:2]) && $stable(beat_addr_pair[ADDR_W-1:2])));

    assert_linear_sdr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && !ilv_q && !op_ddr) |=> (beat_addr[1:0] == 2'($past(beat_addr[1:0]) + 2'd1)));

    assert_ddr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && !ilv_q && op_ddr) |=> (beat_addr[1:0] == 2'($past(beat_addr[1:0]) + 2'd2)));

endmodule

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1, ctl_rw = 1'b0, ctl_sdr = 1'b1, order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] beat_addr, beat_addr_pair;
    logic          burst_active, op_write, op_ddr, out_en;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    burst_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ctl_rw(ctl_rw), .ctl_sdr(ctl_sdr),
        .order_ilv(order_ilv), .addr_in(addr_in), .beat_addr(beat_addr),
        .beat_addr_pair(beat_addr_pair), .burst_active(burst_active),
        .op_write(op_write), .op_ddr(op_ddr), .out_en(out_en)
    );

    // Behavioural reference model.
    int m_act = 0, m_wr = 0, m_ddr = 0, m_ilv = 0, m_up = 0, m_st = 0, m_n = 0, m_oe = 0;

    function automatic int ord(int s, int n, int ilv);
        return ilv != 0 ? ((s ^ n) & 3) : ((s + n) & 3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_wr = 0; m_ddr = 0; m_ilv = 0; m_up = 0; m_st = 0; m_n = 0; m_oe = 0;
        end else begin
            m_oe = (m_act != 0 && m_wr == 0) ? 1 : 0;
            if (!ld_n) begin
                m_act = 1; m_wr = ctl_rw ? 0 : 1; m_ddr = ctl_sdr ? 0 : 1;
                m_ilv = order_ilv ? 1 : 0; m_up = int'(addr_in) >> 2; m_st = int'(addr_in) & 3; m_n = 0;
            end else if (ctl_rw && m_act != 0) begin
                m_n = (m_n + (m_ddr != 0 ? 2 : 1)) & 3;
            end else begin
                m_act = 0;
            end
        end
    end

    task automatic chk(string fld, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    task automatic compare();
        chk("beat_addr", int'(beat_addr), (m_up << 2) | ord(m_st, m_n, m_ilv));
        chk("beat_addr_pair", int'(beat_addr_pair), (m_up << 2) | ord(m_st, m_n + 1, m_ilv));
        chk("burst_active", int'(burst_active), m_act);
        chk("op_write", int'(op_write), m_wr);
        chk("op_ddr", int'(op_ddr), m_ddr);
        chk("out_en", int'(out_en), m_oe);
    endtask

    // Drive one cycle at the falling edge, then compare at the next falling edge.
    task automatic cyc(logic l, logic rw, logic sdr, logic ilv, int a);
        ld_n = l; ctl_rw = rw; ctl_sdr = sdr; order_ilv = ilv; addr_in = AW'(a);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic load(logic rw, logic sdr, logic ilv, int a); cyc(1'b0, rw, sdr, ilv, a); endtask
    task automatic cont(int n); for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 32'h155); endtask
    task automatic nop(int n);  for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 0); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk); compare();
        end
        rst_n = 1'b1;
        nop(1);
        // R1: explicit idle values after reset
        chk("R1 idle active", int'(burst_active), 0);
        chk("R1 idle out_en", int'(out_en), 0);
        // R3 / R6: interleaved single-rate read from every start, past four beats
        for (int s = 0; s < 4; s++) begin
            tag = "R3"; load(1'b1, 1'b1, 1'b1, 32'h2A5C0 | s); cont(3);
            tag = "R6"; cont(2);
            tag = "R8"; nop(2);
        end
        // R4 / R6: linear single-rate read from every start
        for (int s = 0; s < 4; s++) begin
            tag = "R4"; load(1'b1, 1'b1, 1'b0, 32'h13370 | s); cont(3);
            tag = "R6"; cont(3);
            tag = "R8"; nop(2);
        end
        // R5: double-rate bursts, both orders, odd starts
        tag = "R5"; load(1'b1, 1'b0, 1'b0, 32'h00F03); cont(3);
        tag = "R5"; load(1'b1, 1'b0, 1'b1, 32'h3FFF1); cont(3);
        tag = "R8"; nop(1);
        // R10: write burst keeps out_en low; read right after a write
        tag = "R10"; load(1'b0, 1'b1, 1'b0, 32'h01002); cont(2);
        tag = "R10"; load(1'b0, 1'b0, 1'b1, 32'h01005); cont(1);
        tag = "R10"; load(1'b1, 1'b1, 1'b0, 32'h01006); cont(1); nop(2);
        // R9: continues while idle with a moving address
        tag = "R9";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 32'h2F00 + i);
        // R7: upper bits hold while addr_in changes during continues
        tag = "R7"; load(1'b1, 1'b1, 1'b0, 32'h2AAA9);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 32'h15550 + i);
        // R11: mode pins toggled during continues are ignored
        tag = "R11"; load(1'b1, 1'b1, 1'b1, 32'h00042);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 0);
        // R2: back-to-back loads of differing kinds
        tag = "R2"; load(1'b0, 1'b0, 1'b0, 32'h3ABCD);
        tag = "R2"; load(1'b1, 1'b1, 1'b1, 32'h00007);
        tag = "R8"; nop(3);
        // R1: reset mid-burst returns to idle
        tag = "R1"; load(1'b1, 1'b0, 1'b1, 32'h12341); cont(1);
        rst_n = 1'b0; nop(2); rst_n = 1'b1; nop(1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule